// File: doc/BRIEF.md
# ADC Conversion Trigger Selector

This block chooses which of several flag-style event inputs launches an analog-to-digital conversion. A select code routes one of six peripheral event flags, or the converter's own conversion-complete flag, onto a single trigger line. A registered start pulse, one clock long, is issued on each rising edge of that line. The pulse is issued only when both the auto-trigger enable and the converter enable are high.

Edge detection sits after the multiplexer, not on each source. Changing the select code can therefore create a trigger by itself. The one exception is a switch into free-running mode, where the event is suppressed even if the conversion-complete flag is already set. In free-running mode, each completed conversion starts the next one.

A two-state machine holds the last sampled trigger level. Its states are LV_LOW and LV_HIGH. The transition LV_LOW→LV_HIGH is taken when the selected level is high, and it fires the start pulse unless it is the entry into free-running mode. The transition LV_HIGH→LV_LOW is taken when the selected level is low. In each state, a clock with an unchanged level keeps the state.

Top module: `adc_trig_sel`

## Requirements
- R1: `src_sel_i` routes the trigger level as follows. Code 000 selects `conv_done_i`. Codes 001 to 110 select `src_flags_i[code-1]`, where bit 0 is the analog comparator, bit 1 external interrupt 0, bit 2 timer compare A, bit 3 timer overflow, bit 4 timer compare B and bit 5 pin change.
- R2: Code 111 selects no source. Its level is low, so it never produces a start pulse.
- R3: A rising edge of the selected level makes `start_o` high for exactly one clock, starting at the first clock edge after the rise. A level that stays high produces no further pulse.
- R4: While `auto_en_i` is low, no start pulse is produced. Raising `auto_en_i` while the selected level is already high does not produce a pulse.
- R5: While `adc_en_i` is low, no start pulse is produced.
- R6: Changing the select code from a source whose flag is low to a source whose flag is high produces a start pulse.
- R7: Changing the select code into 000 never produces a pulse at that edge, even when `conv_done_i` is high. A later rise of `conv_done_i` does produce a pulse.
- R8: In mode 000, each rising edge of `conv_done_i` produces one start pulse.
- R9: `trig_level_o` equals the selected level sampled at the previous clock edge. It follows the selected level even while either enable is low.
- R10: While `rst_n` is low, `start_o` and `trig_level_o` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 3 | Trigger source select code |
| auto_en_i | input | 1 | Auto-trigger enable |
| adc_en_i | input | 1 | Converter enable |
| conv_done_i | input | 1 | Conversion-complete flag |
| src_flags_i | input | 6 | Peripheral event flags, bit mapping given in R1 |
| start_o | output | 1 | One-clock start-conversion pulse |
| trig_level_o | output | 1 | Registered selected trigger level |

## Verification
Each peripheral code is first checked with every other flag high and its own flag low, then with its own flag raised alone. The first pattern tells the correct routing apart from a shifted or swapped mapping. Select-code switches are tried between a low source and a high source, into code 111 with every flag set, and into free running with the complete flag set. These cases separate edge detection after the multiplexer from a wrong or missing suppression of the false edge. Level changes made with each enable low show that the enables gate the pulse but not the stored level.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned SRC_NUM = 6;

    typedef enum logic [SEL_W-1:0] {
        SRC_FREE = 3'd0,
        SRC_ACMP = 3'd1,
        SRC_EXT0 = 3'd2,
        SRC_CMPA = 3'd3,
        SRC_OVF  = 3'd4,
        SRC_CMPB = 3'd5,
        SRC_PCHG = 3'd6,
        SRC_NONE = 3'd7
    } src_code_e;

    typedef enum logic {
        LV_LOW  = 1'b0,
        LV_HIGH = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/adc_trig_mux.sv
module adc_trig_mux #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               done_i,
    input  logic [NUM_SRC-1:0] flags_i,
    output logic               level_o
);
    localparam int unsigned NUM_CODES = 2 ** SEL_W;

    logic [NUM_CODES-1:0] cand;

    // code 0 = conversion complete, codes 1..NUM_SRC = peripherals, rest = none
    assign cand[0] = done_i;
    for (genvar g = 1; g < NUM_CODES; g++) begin : g_cand
        if (g <= NUM_SRC) begin : g_src
            assign cand[g] = flags_i[g-1];
        end else begin : g_none
            assign cand[g] = 1'b0;
        end
    end

    assign level_o = cand[sel_i];

    if (NUM_SRC + 1 < NUM_CODES) begin : g_chk_none
        always_comb begin
            // R2: the all-ones code never yields a high level
            a_r2_none_quiet: assert (sel_i != {SEL_W{1'b1}} || !level_o);
        end
    end

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_trig_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             level_i,
    input  logic             done_i,
    input  logic             auto_en_i,
    input  logic             adc_en_i,
    output logic             start_o,
    output logic             trig_level_o
);
    lvl_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             enter_free;
    logic             start_d;

    assign enter_free = (sel_i == SEL_W'(SRC_FREE)) && (sel_q != SEL_W'(SRC_FREE));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (enter_free) begin
            state_d = done_i ? LV_HIGH : LV_LOW;
        end else begin
            unique case (state_q)
                LV_LOW:  if (level_i)  state_d = LV_HIGH;
                LV_HIGH: if (!level_i) state_d = LV_LOW;
            endcase
        end
    end

    // pulse decision
    always_comb begin
        start_d = 1'b0;
        unique case (state_q)
            LV_LOW:  start_d = level_i && auto_en_i && adc_en_i && !enter_free;
            LV_HIGH: start_d = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_LOW;
            sel_q   <= SEL_W'(SRC_FREE);
        end else begin
            state_q <= state_d;
            sel_q   <= sel_i;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= 1'b0;
        end else begin
            start_o <= start_d;
        end
    end

    assign trig_level_o = (state_q == LV_HIGH);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    a_r3_rising_only: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (trig_level_o && !$past(trig_level_o)));
    a_r4_auto_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en_i |=> !start_o);
    a_r5_adc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en_i |=> !start_o);
    a_r7_free_entry: assert property (@(posedge clk) disable iff (!rst_n)
        enter_free |=> !start_o);
    a_r9_level_track: assert property (@(posedge clk) disable iff (!rst_n)
        !enter_free |=> (trig_level_o == $past(level_i)));

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int unsigned NUM_SRC = adc_trig_pkg::SRC_NUM,
    parameter int unsigned SEL_W   = adc_trig_pkg::SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   src_sel_i,
    input  logic               auto_en_i,
    input  logic               adc_en_i,
    input  logic               conv_done_i,
    input  logic [NUM_SRC-1:0] src_flags_i,
    output logic               start_o,
    output logic               trig_level_o
);
    logic sel_level;

    adc_trig_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_mux (
        .sel_i   (src_sel_i),
        .done_i  (conv_done_i),
        .flags_i (src_flags_i),
        .level_o (sel_level)
    );

    adc_trig_edge #(
        .SEL_W (SEL_W)
    ) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (src_sel_i),
        .level_i      (sel_level),
        .done_i       (conv_done_i),
        .auto_en_i    (auto_en_i),
        .adc_en_i     (adc_en_i),
        .start_o      (start_o),
        .trig_level_o (trig_level_o)
    );

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!start_o && !trig_level_o) || rst_n);

endmodule

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel_i = 3'd1;
    logic       auto_en_i = 1'b1;
    logic       adc_en_i = 1'b1;
    logic       conv_done_i = 1'b0;
    logic [5:0] src_flags_i = 6'd0;
    logic       start_o;
    logic       trig_level_o;

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    always #4 clk = ~clk;

    adc_trig_sel u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_sel_i    (src_sel_i),
        .auto_en_i    (auto_en_i),
        .adc_en_i     (adc_en_i),
        .conv_done_i  (conv_done_i),
        .src_flags_i  (src_flags_i),
        .start_o      (start_o),
        .trig_level_o (trig_level_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R10 start in reset", start_o, 1'b0);
        chk("R10 level in reset", trig_level_o, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R10 start after reset", start_o, 1'b0);
    endtask

    task automatic t_sources();
        for (int c = 1; c <= 6; c++) begin
            src_sel_i   = 3'(c);
            src_flags_i = 6'd0;
            tick(); tick();
            src_flags_i = ~(6'd1 << (c - 1));
            tick();
            chk($sformatf("R1 others high code %0d", c), start_o, 1'b0);
            src_flags_i = 6'h3f;
            tick();
            chk($sformatf("R1 own flag code %0d", c), start_o, 1'b1);
            chk($sformatf("R9 level code %0d", c), trig_level_o, 1'b1);
            tick();
            chk($sformatf("R3 one clock code %0d", c), start_o, 1'b0);
            tick();
            chk($sformatf("R3 held high code %0d", c), start_o, 1'b0);
            src_flags_i = 6'd0;
            tick();
            chk($sformatf("R9 level falls code %0d", c), trig_level_o, 1'b0);
        end
    endtask

    task automatic t_none();
        src_sel_i   = 3'd7;
        src_flags_i = 6'h3f;
        conv_done_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 none start", start_o, 1'b0);
            chk("R2 none level", trig_level_o, 1'b0);
        end
        src_flags_i = 6'd0;
        conv_done_i = 1'b0;
        tick();
    endtask

    task automatic t_switch();
        src_sel_i   = 3'd1;
        src_flags_i = 6'b000010;
        tick(); tick();
        chk("R6 low source quiet", start_o, 1'b0);
        src_sel_i = 3'd2;
        tick();
        chk("R6 switch to high source", start_o, 1'b1);
        tick();
        chk("R6 pulse ends", start_o, 1'b0);
        src_flags_i = 6'd0;
        tick();
    endtask

    task automatic t_enter_free();
        src_sel_i   = 3'd1;
        conv_done_i = 1'b1;
        tick(); tick();
        src_sel_i = 3'd0;
        tick();
        chk("R7 no pulse on entry", start_o, 1'b0);
        chk("R7 level loaded", trig_level_o, 1'b1);
        tick();
        chk("R7 still quiet", start_o, 1'b0);
        conv_done_i = 1'b0;
        tick();
        conv_done_i = 1'b1;
        tick();
        chk("R7 later rise fires", start_o, 1'b1);
        conv_done_i = 1'b0;
        tick();
    endtask

    task automatic t_free();
        src_sel_i = 3'd0;
        for (int i = 0; i < 3; i++) begin
            conv_done_i = 1'b1;
            tick();
            chk("R8 complete rise", start_o, 1'b1);
            conv_done_i = 1'b0;
            tick();
            chk("R8 pulse ends", start_o, 1'b0);
        end
    endtask

    task automatic t_auto_low();
        src_sel_i   = 3'd4;
        src_flags_i = 6'd0;
        tick();
        auto_en_i = 1'b0;
        src_flags_i = 6'b001000;
        tick();
        chk("R4 no pulse when disabled", start_o, 1'b0);
        chk("R9 level tracks when disabled", trig_level_o, 1'b1);
        auto_en_i = 1'b1;
        tick();
        chk("R4 no pulse on enable with high level", start_o, 1'b0);
        src_flags_i = 6'd0;
        tick();
    endtask

    task automatic t_adc_low();
        src_sel_i   = 3'd6;
        src_flags_i = 6'd0;
        tick();
        adc_en_i = 1'b0;
        src_flags_i = 6'b100000;
        tick();
        chk("R5 no pulse with converter off", start_o, 1'b0);
        src_flags_i = 6'd0;
        tick();
        adc_en_i = 1'b1;
        src_flags_i = 6'b100000;
        tick();
        chk("R5 pulse with converter on", start_o, 1'b1);
        src_flags_i = 6'd0;
        tick();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sources();
        t_none();
        t_switch();
        t_enter_free();
        t_free();
        t_auto_low();
        t_adc_low();
        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done_run) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule